// File: doc/BRIEF.md
# Read Flow-Through Gating Controller

This controller sits between the read-data queue of a bridge and the bus engine that hands read data back to the initiator of a bridged read. It decides the cycle in which buffered data may start flowing to the initiator, and the cycle in which the initiator should be disconnected. The decision depends on how much faster the initiator side is than the target side, on the read command, on whether the address range is prefetchable, and on the initiator cache line size.

With equal bandwidth on both sides, data flows as soon as anything is queued. At a 2:1 mismatch the block runs in limited flow-through. It waits for a threshold that depends on the command and the line size. It cuts the burst at the standard prefetch boundary, and it gives up after seven dry cycles. At 4:1 or more, nothing is returned until the target-side read has finished. The queue storage and the bus protocol engines are outside this block. The configuration inputs must be held stable while `req_active` is high.

Top module: `rfg_gate`

## Requirements
- R1: During reset and in the first cycle after it, `release_data` and `disc_req` are 0.
- R2: With `ratio_sel`=0 (1:1), `release_data` rises at the first clock edge where `q_fill` is nonzero.
- R3: With `ratio_sel`=1 (2:1), `rd_cmd`=2 (memory read multiple) and a line of 16 or 32 doublewords (`line_sel` 1 or 2), release happens once `q_fill` reaches one full line.
- R4: At 2:1 with a 16 or 32 doubleword line, memory read line (`rd_cmd`=1) and prefetchable memory read (`rd_cmd`=0 or 3 with `prefetchable`=1) release at half a line. A non-prefetchable memory read releases at 1 doubleword.
- R5: At 2:1 with an 8 doubleword line (`line_sel`=0), every command releases at 2 doublewords, except a non-prefetchable memory read, which releases at 1. The unsupported `line_sel`=3 behaves as 8 doublewords.
- R6: With `ratio_sel` 2 or 3 (4:1), `release_data` stays 0 whatever the fill while `tgt_done`=0. It rises at the first edge where `tgt_done`=1 and `q_fill` is nonzero.
- R7: At 2:1, a nonzero `q_fill` below the threshold is released at the first edge where `tgt_done`=1.
- R8: At 2:1, after release and with `tgt_done`=0, `disc_req` rises at the seventh consecutive edge with `q_fill`=0. Any edge with `q_fill` nonzero restarts that count.
- R9: At 2:1, after release, `disc_req` rises at the edge that takes the doubleword that reaches the prefetch boundary. The doubleword count is `xfer_dw` high while released. The boundary is 2 lines for memory read multiple, 1 doubleword for a non-prefetchable memory read, and 1 line otherwise.
- R10: While `req_active` is 0, both outputs clear at the next edge. While `req_active` is 1, both outputs stay set once set.
- R11: At 1:1, neither the dry-queue timeout nor the prefetch boundary ever raises `disc_req`.
- R12: After release, an edge with `tgt_done`=1 and `q_fill`=0 raises `disc_req`, at any ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_active | input | 1 | A bridged read is in progress |
| ratio_sel | input | 2 | Bandwidth ratio: 0 = 1:1, 1 = 2:1, 2/3 = 4:1 |
| rd_cmd | input | 2 | 0 = memory read, 1 = read line, 2 = read multiple, 3 = as 0 |
| prefetchable | input | 1 | Address lies in a prefetchable range |
| line_sel | input | 2 | Cache line: 0 = 8, 1 = 16, 2 = 32 doublewords, 3 = as 0 |
| q_fill | input | FILL_W | Doublewords currently in the read queue |
| tgt_done | input | 1 | Target-side read has completed |
| xfer_dw | input | 1 | One doubleword handed to the initiator this cycle |
| release_data | output | 1 | Queued data may flow to the initiator |
| disc_req | output | 1 | Request disconnect of the initiator |

## Verification
Both outputs are registers fed straight from the current inputs. Every result is therefore due at the first rising edge after the inputs that cause it, and the dry timeout is due at the seventh empty edge. The bench changes inputs only on falling edges and reads the outputs on the next falling edge, so each sample sees exactly one more edge. The threshold sweep raises `q_fill` by one per cycle. The fill value shown at the first sample with `release_data` high is the threshold, and it is compared with a value computed arithmetically for every ratio, command, range and line code. The timeout and boundary checks count edges from the release, sample one edge before the expected one and again at it, and so pin the exact cycle.

// File: rtl/rfg_pkg.sv
package rfg_pkg;
  localparam logic [1:0] RATIO_1TO1 = 2'd0;
  localparam logic [1:0] RATIO_2TO1 = 2'd1;
  localparam logic [1:0] CMD_MRL    = 2'd1;
  localparam logic [1:0] CMD_MRM    = 2'd2;
  localparam int LINE_BASE_DW   = 8;
  localparam int LINE_SIZES     = 3;
  localparam int SMALL_LINE_THR = 2;
  localparam int DRY_WAIT       = 7;
endpackage

// File: rtl/rfg_thresh.sv
module rfg_thresh
  import rfg_pkg::*;
#(
  parameter int BND_W = 7
) (
  input  logic [1:0]       ratio_sel,
  input  logic [1:0]       rd_cmd,
  input  logic             prefetchable,
  input  logic [1:0]       line_sel,
  output logic [BND_W-1:0] thr,
  output logic [BND_W-1:0] bnd,
  output logic             direct,
  output logic             limited,
  output logic             hold_all
);
  logic [BND_W-1:0] line;
  logic [BND_W-1:0] base;
  logic             is_mrm;
  logic             is_mrl;
  logic             single;

  always_comb begin
    if (int'(line_sel) < LINE_SIZES)
      line = BND_W'(LINE_BASE_DW) << line_sel;
    else
      line = BND_W'(LINE_BASE_DW);
    is_mrm = (rd_cmd == CMD_MRM);
    is_mrl = (rd_cmd == CMD_MRL);
    single = !is_mrm && !is_mrl && !prefetchable;
    if (is_mrm)
      bnd = line << 1;
    else if (single)
      bnd = BND_W'(1);
    else
      bnd = line;
    if (line == BND_W'(LINE_BASE_DW))
      base = BND_W'(SMALL_LINE_THR);
    else if (is_mrm)
      base = line;
    else
      base = line >> 1;
    thr      = (base < bnd) ? base : bnd;
    direct   = (ratio_sel == RATIO_1TO1);
    limited  = (ratio_sel == RATIO_2TO1);
    hold_all = !direct && !limited;
  end
endmodule

// File: rtl/rfg_drywait.sv
module rfg_drywait #(
  parameter int WAIT_CYC = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic armed,
  input  logic empty,
  output logic expired
);
  localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  logic [CNT_W-1:0] cnt;

  assign expired = armed && empty && (cnt == CNT_W'(WAIT_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || clear || !armed || !empty)
      cnt <= '0;
    else if (!expired)
      cnt <= cnt + 1'b1;
  end

  AST_DRY_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) < WAIT_CYC); // R8
  AST_DRY_RESTART_ON_DATA: assert property (@(posedge clk) disable iff (rst)
    !empty |=> cnt == '0); // R8
endmodule

// File: rtl/rfg_burstcnt.sv
module rfg_burstcnt #(
  parameter int BND_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             take,
  input  logic [BND_W-1:0] bnd,
  output logic             at_limit
);
  logic [BND_W-1:0] cnt;

  assign at_limit = take && ((int'(cnt) + 1) >= int'(bnd));

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt <= '0;
    else if (take && !at_limit)
      cnt <= cnt + 1'b1;
  end

  AST_BURST_BELOW_BOUND: assert property (@(posedge clk) disable iff (rst)
    bnd != '0 |-> cnt < bnd); // R9
endmodule

// File: rtl/rfg_gate.sv
module rfg_gate
  import rfg_pkg::*;
#(
  parameter int FILL_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_active,
  input  logic [1:0]        ratio_sel,
  input  logic [1:0]        rd_cmd,
  input  logic              prefetchable,
  input  logic [1:0]        line_sel,
  input  logic [FILL_W-1:0] q_fill,
  input  logic              tgt_done,
  input  logic              xfer_dw,
  output logic              release_data,
  output logic              disc_req
);
  localparam int MAX_BURST = 2 * (LINE_BASE_DW << (LINE_SIZES - 1));
  localparam int BND_W     = $clog2(MAX_BURST + 1);

  logic [BND_W-1:0] thr;
  logic [BND_W-1:0] bnd;
  logic direct, limited, hold_all;
  logic rel_q, disc_q;
  logic has_data, thr_met, go, drained, dry_hit, bnd_hit;

  rfg_thresh #(.BND_W(BND_W)) u_thresh (
    .ratio_sel(ratio_sel), .rd_cmd(rd_cmd), .prefetchable(prefetchable),
    .line_sel(line_sel), .thr(thr), .bnd(bnd), .direct(direct),
    .limited(limited), .hold_all(hold_all)
  );

  rfg_drywait #(.WAIT_CYC(DRY_WAIT)) u_dry (
    .clk(clk), .rst(rst), .clear(!req_active),
    .armed(rel_q && limited && !tgt_done && !disc_q),
    .empty(!has_data), .expired(dry_hit)
  );

  rfg_burstcnt #(.BND_W(BND_W)) u_burst (
    .clk(clk), .rst(rst), .clear(!req_active),
    .take(xfer_dw && rel_q), .bnd(bnd), .at_limit(bnd_hit)
  );

  always_comb begin
    has_data = (q_fill != '0);
    thr_met  = int'(q_fill) >= int'(thr);
    drained  = tgt_done && !has_data;
    if (direct)
      go = has_data;
    else if (hold_all)
      go = tgt_done && has_data;
    else
      go = thr_met || (tgt_done && has_data);
  end

  always_ff @(posedge clk) begin
    if (rst || !req_active) begin
      rel_q  <= 1'b0;
      disc_q <= 1'b0;
    end else begin
      if (go)
        rel_q <= 1'b1;
      if (rel_q && (drained || (limited && (dry_hit || bnd_hit))))
        disc_q <= 1'b1;
    end
  end

  assign release_data = rel_q;
  assign disc_req     = disc_q;

  AST_RELEASE_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(release_data) |-> $past(q_fill) != '0); // R2
  AST_WIDE_RATIO_WAITS: assert property (@(posedge clk) disable iff (rst)
    ($rose(release_data) && $past(ratio_sel) >= 2'd2) |-> $past(tgt_done)); // R6
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !req_active |=> (!release_data && !disc_req)); // R10
  AST_OUTPUTS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (req_active && release_data) |=> release_data); // R10
  AST_DISC_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    disc_req |-> release_data); // R9
  AST_EQUAL_RATIO_NO_LIMIT: assert property (@(posedge clk) disable iff (rst)
    ($rose(disc_req) && $past(ratio_sel) == 2'd0) |-> $past(tgt_done)); // R11
endmodule

// File: tb/sim_rfg_gate.sv
`timescale 1ns/1ps
module sim_rfg_gate;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_active = 1'b0;
  logic [1:0] ratio_sel = 2'd0;
  logic [1:0] rd_cmd = 2'd0;
  logic prefetchable = 1'b0;
  logic [1:0] line_sel = 2'd0;
  logic [6:0] q_fill = 7'd0;
  logic tgt_done = 1'b0;
  logic xfer_dw = 1'b0;
  logic release_data, disc_req;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rfg_gate #(.FILL_W(7)) u0 (
    .clk(clk), .rst(rst), .req_active(req_active), .ratio_sel(ratio_sel),
    .rd_cmd(rd_cmd), .prefetchable(prefetchable), .line_sel(line_sel),
    .q_fill(q_fill), .tgt_done(tgt_done), .xfer_dw(xfer_dw),
    .release_data(release_data), .disc_req(disc_req)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_thr(int r, int c, int p, int l);
    int line, bnd, base;
    line = (l == 3) ? 8 : (8 << l);
    if (r == 0) return 1;
    if (r >= 2) return -1;
    if (c == 2) bnd = 2 * line;
    else if (c != 1 && p == 0) bnd = 1;
    else bnd = line;
    if (line == 8) base = 2;
    else if (c == 2) base = line;
    else base = line / 2;
    return (base < bnd) ? base : bnd;
  endfunction

  task automatic setup(input int r, input int c, input int p, input int l);
    req_active = 0; q_fill = 0; tgt_done = 0; xfer_dw = 0;
    step();
    ratio_sel = 2'(r); rd_cmd = 2'(c); prefetchable = p[0]; line_sel = 2'(l);
    req_active = 1;
  endtask

  initial begin
    @(negedge clk);
    step();
    chk("R1 release in reset", int'(release_data), 0);
    chk("R1 disc in reset", int'(disc_req), 0);
    rst = 0;
    step();
    chk("R1 release after reset", int'(release_data), 0);
    chk("R1 disc after reset", int'(disc_req), 0);

    // threshold sweep over every configuration code
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        for (int p = 0; p < 2; p++)
          for (int l = 0; l < 4; l++) begin
            string tag;
            int first;
            first = -1;
            if (r == 0) tag = "R2";
            else if (r >= 2) tag = "R6";
            else if (l == 0 || l == 3) tag = "R5";
            else if (c == 2) tag = "R3";
            else tag = "R4";
            setup(r, c, p, l);
            for (int k = 0; k < 70; k++) begin
              q_fill = 7'(k);
              step();
              if (release_data && first < 0) first = k;
            end
            chk($sformatf("%s threshold r%0d c%0d p%0d l%0d", tag, r, c, p, l),
                first, exp_thr(r, c, p, l));
          end

    // R10: clear on idle
    setup(0, 0, 0, 0);
    q_fill = 1; step();
    tgt_done = 1; q_fill = 0; step();
    chk("R12 drained disconnect", int'(disc_req), 1);
    req_active = 0; step();
    chk("R10 release cleared", int'(release_data), 0);
    chk("R10 disc cleared", int'(disc_req), 0);

    // R6: 4:1 holds until target completes
    setup(2, 2, 1, 1);
    q_fill = 40;
    for (int i = 0; i < 5; i++) step();
    chk("R6 held without completion", int'(release_data), 0);
    q_fill = 0; tgt_done = 1; step();
    chk("R6 empty queue not released", int'(release_data), 0);
    q_fill = 3; step();
    chk("R6 released after completion", int'(release_data), 1);

    // R7: partial fill released on completion
    setup(1, 2, 1, 2);
    q_fill = 5;
    for (int i = 0; i < 3; i++) step();
    chk("R7 below threshold held", int'(release_data), 0);
    tgt_done = 1; step();
    chk("R7 released on completion", int'(release_data), 1);

    // R8: dry-queue timeout with restart
    setup(1, 2, 0, 0);
    q_fill = 2; step();
    chk("R8 released", int'(release_data), 1);
    q_fill = 0;
    for (int i = 0; i < 6; i++) step();
    chk("R8 six dry edges", int'(disc_req), 0);
    q_fill = 1; step();
    q_fill = 0;
    for (int i = 0; i < 6; i++) step();
    chk("R8 restarted count", int'(disc_req), 0);
    step();
    chk("R8 seventh dry edge", int'(disc_req), 1);
    for (int i = 0; i < 3; i++) step();
    chk("R10 disc sticky", int'(disc_req), 1);

    // R9: prefetch boundary, read line at 16 doublewords
    setup(1, 1, 0, 1);
    q_fill = 8; step();
    chk("R9 released", int'(release_data), 1);
    xfer_dw = 1;
    for (int i = 0; i < 15; i++) step();
    chk("R9 before boundary", int'(disc_req), 0);
    step();
    chk("R9 at boundary", int'(disc_req), 1);

    // R11: 1:1 ignores dry timeout and boundary
    setup(0, 0, 0, 0);
    q_fill = 1; step();
    xfer_dw = 1; q_fill = 0;
    for (int i = 0; i < 20; i++) step();
    chk("R11 no limit disconnect", int'(disc_req), 0);
    chk("R11 release kept", int'(release_data), 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule